// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides a reference clock into the 16x oversampling tick that a UART receiver and transmitter run on. The divisor has a 16-bit integer part, given as an upper and a lower byte, and a 4-bit fraction counted in sixteenths. Most sample ticks last the integer number of reference cycles. Within each group of sixteen ticks, a number of ticks equal to the fraction last one cycle longer. An accumulator spreads those longer ticks evenly over the group. The average tick period is therefore integer + fraction/16 reference cycles. This lets a non-ideal reference clock reach high bit rates with small error. For example, with a 24 MHz reference, integer 1 and fraction 10 give 26 cycles per bit, close to 921600 baud.

A second output marks every sixteenth sample tick, which is the end of a bit period. Any change on the divisor inputs restarts the tick sequence from the start of a bit. An integer part of zero, or a low enable, stops the ticks.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, both tick outputs are low and stay low until the block is enabled with a non-zero integer divisor.
- R2: While the integer divisor ({div_hi, div_lo}) is zero, no sample tick or bit tick is produced, whatever the fraction.
- R3: While en is low, no tick is produced and the tick sequence is cleared.
- R4: Sample tick number k (counted from 0 at a restart) lasts I+1 reference cycles if floor(((k mod 16)+1)·F/16) > floor((k mod 16)·F/16), and I cycles otherwise. Here I is the integer divisor and F is the fraction.
- R5: Each bit period spans exactly 16·I+F reference cycles, counted from the restart or from the previous bit tick.
- R6: bit_tick is high together with sample ticks 15, 31, 47 and so on, and never at any other time.
- R7: A change on div_hi, div_lo or div_frac is taken at the next clock edge and restarts the sequence. The first sample tick is then visible p0+1 cycles after the inputs change, where p0 is the period of tick 0.
- R8: div_hi is the upper byte of the integer divisor and div_lo is the lower byte.
- R9: Each tick output is a registered level that is high for one reference cycle per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Tick generation enable |
| div_hi | input | 8 | Integer divisor, upper byte |
| div_lo | input | 8 | Integer divisor, lower byte |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| sample_tick | output | 1 | 16x oversampling tick |
| bit_tick | output | 1 | Tick on the last sample of each bit |

## Verification
The hardest case to reach from the ports is a restart in the middle of a bit period. At that point the accumulator and the cycle count are both part-way through a group. The stimulus starts one divisor, lets it run for part of a bit, and then writes a new divisor with en still high. It then checks the exact arrival time of every later tick. The upper divisor byte is exercised with a divisor above 255, which gives a bit period of several thousand cycles.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int BYTE_W = 8;
    localparam int FRAC_W = 4;
endpackage

// File: rtl/fbg_cfg_track.sv
module fbg_cfg_track #(
    parameter int BYTE_W = fbg_pkg::BYTE_W,
    parameter int FRAC_W = fbg_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    input  logic [FRAC_W-1:0] frac,
    output logic              changed
);
    localparam int CW = 2*BYTE_W + FRAC_W;

    typedef struct packed {
        logic [CW-1:0] cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cfg = {hi, lo, frac};
        changed  = (st_d.cfg != st_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fbg_frac_spread.sv
module fbg_frac_spread #(
    parameter int FRAC_W = fbg_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] frac,
    input  logic              run,
    input  logic              clear,
    input  logic              advance,
    output logic              stretch,
    output logic              last
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic [FRAC_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, frac};
        stretch = sum[FRAC_W];
        last    = &st_q.idx;
        st_d    = st_q;
        if (clear || !run) begin
            st_d = '0;
        end else if (advance) begin
            st_d.acc = sum[FRAC_W-1:0];
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The accumulator returns to zero at the start of every sample group.
    assert_acc_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx == '0) |-> (st_q.acc == '0));
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
    parameter int INT_W = 2*fbg_pkg::BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] whole,
    input  logic             stretch,
    input  logic             run,
    input  logic             clear,
    output logic             fire
);
    typedef struct packed {
        logic [INT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [INT_W:0] lim;

    always_comb begin
        lim  = {1'b0, whole} - 1'b1 + {{INT_W{1'b0}}, stretch};
        fire = run && !clear && ({1'b0, st_q.cnt} == lim);
        st_d = st_q;
        if (clear || !run || fire) st_d.cnt = '0;
        else                       st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The count never passes the longest allowed tick period.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |-> ({1'b0, st_q.cnt} <= {1'b0, whole}));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int BYTE_W = fbg_pkg::BYTE_W,
    parameter int FRAC_W = fbg_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int INT_W = 2*BYTE_W;

    typedef struct packed {
        logic sample;
        logic bitend;
    } tk_t;

    tk_t tk_d, tk_q;
    logic [INT_W-1:0] whole;
    logic run, clear, stretch, last, fire;

    assign whole = {div_hi, div_lo};   // R8: upper byte first
    assign run   = en && (whole != '0);

    fbg_cfg_track #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_track (
        .clk(clk), .rst_n(rst_n), .hi(div_hi), .lo(div_lo),
        .frac(div_frac), .changed(clear)
    );

    fbg_frac_spread #(.FRAC_W(FRAC_W)) u_spread (
        .clk(clk), .rst_n(rst_n), .frac(div_frac), .run(run),
        .clear(clear), .advance(fire), .stretch(stretch), .last(last)
    );

    fbg_period_cnt #(.INT_W(INT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .whole(whole), .stretch(stretch),
        .run(run), .clear(clear), .fire(fire)
    );

    always_comb begin
        tk_d        = tk_q;
        tk_d.sample = fire;
        tk_d.bitend = fire && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign sample_tick = tk_q.sample;
    assign bit_tick    = tk_q.bitend;

    assert_bit_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    assert_zero_div_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (whole == '0) |=> !sample_tick);
    assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sample_tick && !bit_tick));
    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sample_tick);
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div_hi = '0;
    logic [7:0] div_lo = '0;
    logic [3:0] div_frac = '0;
    logic       sample_tick, bit_tick;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .div_hi(div_hi), .div_lo(div_lo),
        .div_frac(div_frac), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int per(input int i, input int f, input int k);
        int kk = k % 16;
        return i + ((((kk+1)*f)/16 > (kk*f)/16) ? 1 : 0);
    endfunction

    // Drives a divisor, then checks the arrival of nt sample ticks.
    task automatic run_cfg(input int i, input int f, input int nt);
        int n = 0;
        int k = 0;
        int exp_t;
        int prev_bit = 1;
        @(negedge clk);
        div_hi = i[15:8]; div_lo = i[7:0]; div_frac = f[3:0]; en = 1'b1;
        exp_t = 1 + per(i, f, 0);
        while (k < nt) begin
            @(negedge clk);
            n++;
            if (sample_tick) begin
                check(n == exp_t, "R4/R7 tick time", n, exp_t);
                check(bit_tick == ((k % 16) == 15), "R6 bit tick", int'(bit_tick), int'((k % 16) == 15));
                if (bit_tick) begin
                    check(n - prev_bit == 16*i + f, "R5 bit period", n - prev_bit, 16*i + f);
                    prev_bit = n;
                end
                k++;
                exp_t += per(i, f, k);
            end else begin
                check(!bit_tick, "R6 bit without sample", int'(bit_tick), 0);
                if (n > exp_t) begin
                    check(1'b0, "R4 missing tick", n, exp_t);
                    break;
                end
            end
        end
    endtask

    task automatic quiet(input int cycles, input string req);
        int seen = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(5 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!sample_tick && !bit_tick, "R1 reset state", int'(sample_tick), 0);
        rst_n = 1'b1;
        quiet(20, "R1 idle after reset");

        // R4 R5 R6 sweep over small integers and every fraction
        for (int i = 1; i <= 3; i++)
            for (int f = 0; f < 16; f++)
                run_cfg(i, f, 34);

        // rate cases: 26, 24, 32, 48, 60, 52 cycles per bit
        run_cfg(1, 10, 32);
        run_cfg(1, 8, 32);
        run_cfg(2, 0, 32);
        run_cfg(3, 0, 32);
        run_cfg(3, 12, 32);
        run_cfg(3, 4, 32);

        // R8: upper byte used, 258 + 5/16
        run_cfg(258, 5, 32);

        // R7: restart in the middle of a bit
        run_cfg(2, 3, 7);
        repeat (3) @(negedge clk);
        run_cfg(3, 7, 20);
        run_cfg(4, 9, 5);

        // R2: integer zero, fraction non-zero and zero
        @(negedge clk); div_hi = 0; div_lo = 0; div_frac = 5; en = 1'b1;
        quiet(60, "R2 zero integer with fraction");
        @(negedge clk); div_frac = 0;
        quiet(60, "R2 zero divisor");

        // R3: enable low
        @(negedge clk); en = 1'b0; div_lo = 2;
        quiet(60, "R3 disabled");
        run_cfg(1, 1, 20);
        @(negedge clk); en = 1'b0;
        quiet(40, "R3 disabled after running");

        // R9: single-cycle pulses with period 2
        begin
            int highs = 0;
            @(negedge clk); div_lo = 2; div_frac = 0; en = 1'b1;
            repeat (4) @(negedge clk);
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (sample_tick) highs++;
            end
            check(highs == 20, "R9 pulse width", highs, 20);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule